// File: doc/BRIEF.md
# Next-PC Generation Unit

This block holds the program counter of a single-cycle 32-bit processor and works out, every clock, which address the counter takes next. Three candidates are formed side by side from the current counter and the instruction word. The first is the fall-through address, four bytes on. The second is a conditional branch target: the fall-through address plus the low 16 instruction bits, sign-extended and scaled by four. The third is a jump target: the top four bits of the fall-through address with the low 26 instruction bits, scaled by four, placed below them.

A fixed-priority selector picks one candidate. The jump request wins over everything else. A branch is taken only when the branch request and the ALU zero flag are both high. In every other case the counter steps forward. The counter has no write enable and loads a new value on every clock. The counter drives the instruction-memory address, and the fall-through address is also brought out for use elsewhere in the datapath.

Top module: `npc_gen_unit`

## Requirements
- R1: A synchronous reset loads the counter with 0x00000000 at the next rising clock edge. While reset is held, `pc_plus4` reads 0x00000004.
- R2: With `jump_ctl`=0 and `branch_ctl`=0, the counter advances by 4 on every clock edge, with no enable.
- R3: `pc_plus4` always equals `pc_out` + 4, taken modulo 2^32.
- R4: With `jump_ctl`=0, `branch_ctl`=1 and `zero_flag`=1, the next counter value is (`pc_out`+4) plus `instr_word[15:0]`, sign-extended to 32 bits and shifted left by 2. This covers the largest forward offset 0x7FFF and the largest backward offset 0x8000.
- R5: With `branch_ctl`=1 and `zero_flag`=0 (and `jump_ctl`=0), the branch is not taken and the counter advances by 4.
- R6: `zero_flag`=1 has no effect while `branch_ctl`=0: the counter advances by 4.
- R7: With `jump_ctl`=1, the next counter value is {(`pc_out`+4)[31:28], `instr_word[25:0]`, 2'b00}, whatever `branch_ctl` and `zero_flag` are.
- R8: Bits [1:0] of the counter are 0 in every cycle.
- R9: Address arithmetic wraps modulo 2^32: stepping from 0xFFFFFFFC gives 0x00000000. The jump region comes from the incremented address, so a jump taken at 0x0FFFFFFC lands in region 0x1.
- R10: Reset takes priority over an active jump or branch request in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_word | input | 32 | Instruction currently fetched; bits [15:0] give the branch offset, bits [25:0] give the jump index |
| zero_flag | input | 1 | ALU zero result for the current instruction |
| branch_ctl | input | 1 | Decoder marks a conditional (equal) branch |
| jump_ctl | input | 1 | Decoder marks an unconditional jump |
| pc_out | output | 32 | Current program counter, instruction-memory address |
| pc_plus4 | output | 32 | Fall-through address, `pc_out` + 4 |

## Verification
Every fault in this block shows up at `pc_out` one clock after the cycle that selected the wrong candidate. A fault in the incrementer shows up at once on `pc_plus4`, because that output is combinational from the counter. The sign-extension and region logic are each checked at the offsets and region boundaries where a truncated or unsigned path would give a different address. A chain of sixteen jumps walks the region bits through every value, and the last one ends at the top of memory, where the wrap to zero is then checked. A wrong selection priority appears as a counter that steps by four when it should land on the jump target, or the reverse.

// File: rtl/npc_pkg.sv
package npc_pkg;

  localparam int XLEN       = 32;
  localparam int INSTR_W    = 32;
  localparam int IMM_W      = 16;
  localparam int JIDX_W     = 26;
  localparam int WORD_SHIFT = 2;
  localparam int STEP       = 1 << WORD_SHIFT;
  localparam int REGION_W   = XLEN - JIDX_W - WORD_SHIFT;

  typedef logic [XLEN-1:0] addr_t;

  typedef enum logic [1:0] {
    SRC_SEQ    = 2'd0,
    SRC_BRANCH = 2'd1,
    SRC_JUMP   = 2'd2
  } npc_src_e;

  // Fall-through address: one word further on.
  function automatic addr_t f_seq(input addr_t pc);
    return pc + addr_t'(STEP);
  endfunction

  // Branch displacement in bytes: sign-extend the immediate, then scale it to words.
  function automatic addr_t f_scaled_off(input logic [IMM_W-1:0] imm);
    addr_t ext;
    ext = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
    return ext << WORD_SHIFT;
  endfunction

  // Branch target, measured from the fall-through address.
  function automatic addr_t f_branch(input addr_t seq, input logic [IMM_W-1:0] imm);
    return seq + f_scaled_off(imm);
  endfunction

  // Jump target: region bits of the fall-through address with the scaled index below them.
  function automatic addr_t f_jump(input addr_t seq, input logic [JIDX_W-1:0] idx);
    return {seq[XLEN-1 -: REGION_W], idx, {WORD_SHIFT{1'b0}}};
  endfunction

endpackage

// File: rtl/npc_seq_adder.sv
module npc_seq_adder
  import npc_pkg::*;
(
  input  addr_t pc_cur,
  output addr_t pc_seq
);

  assign pc_seq = f_seq(pc_cur);

endmodule

// File: rtl/npc_target_calc.sv
module npc_target_calc
  import npc_pkg::*;
(
  input  addr_t              pc_seq,
  input  logic [IMM_W-1:0]   br_imm,
  input  logic [JIDX_W-1:0]  jmp_idx,
  output addr_t              br_tgt,
  output addr_t              jmp_tgt
);

  assign br_tgt  = f_branch(pc_seq, br_imm);
  assign jmp_tgt = f_jump(pc_seq, jmp_idx);

endmodule

// File: rtl/npc_select.sv
module npc_select
  import npc_pkg::*;
(
  input  addr_t    pc_seq,
  input  addr_t    br_tgt,
  input  addr_t    jmp_tgt,
  input  logic     branch_ctl,
  input  logic     zero_flag,
  input  logic     jump_ctl,
  output logic     br_take,
  output npc_src_e src,
  output addr_t    pc_next
);

  assign br_take = branch_ctl & zero_flag;

  // Fixed priority: jump, then taken branch, then fall-through.
  always_comb begin
    if (jump_ctl)     src = SRC_JUMP;
    else if (br_take) src = SRC_BRANCH;
    else              src = SRC_SEQ;
  end

  always_comb begin
    unique case (src)
      SRC_JUMP:   pc_next = jmp_tgt;
      SRC_BRANCH: pc_next = br_tgt;
      default:    pc_next = pc_seq;
    endcase
  end

endmodule

// File: rtl/npc_gen_unit.sv
module npc_gen_unit
  import npc_pkg::*;
#(
  parameter addr_t RESET_ADDR = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INSTR_W-1:0] instr_word,
  input  logic               zero_flag,
  input  logic               branch_ctl,
  input  logic               jump_ctl,
  output logic [XLEN-1:0]    pc_out,
  output logic [XLEN-1:0]    pc_plus4
);

  addr_t    pc_q;
  addr_t    seq_w;
  addr_t    br_tgt_w;
  addr_t    jmp_tgt_w;
  addr_t    next_w;
  logic     br_take_w;
  npc_src_e src_w;
  logic     instr_op_unused;

  // The opcode field is decoded elsewhere and is not needed here.
  assign instr_op_unused = ^instr_word[INSTR_W-1:JIDX_W];

  npc_seq_adder u_seq (
    .pc_cur (pc_q),
    .pc_seq (seq_w)
  );

  npc_target_calc u_tgt (
    .pc_seq  (seq_w),
    .br_imm  (instr_word[IMM_W-1:0]),
    .jmp_idx (instr_word[JIDX_W-1:0]),
    .br_tgt  (br_tgt_w),
    .jmp_tgt (jmp_tgt_w)
  );

  npc_select u_sel (
    .pc_seq     (seq_w),
    .br_tgt     (br_tgt_w),
    .jmp_tgt    (jmp_tgt_w),
    .branch_ctl (branch_ctl),
    .zero_flag  (zero_flag),
    .jump_ctl   (jump_ctl),
    .br_take    (br_take_w),
    .src        (src_w),
    .pc_next    (next_w)
  );

  // Loaded on every edge, with no enable.
  always_ff @(posedge clk) begin
    if (rst) pc_q <= RESET_ADDR;
    else     pc_q <= next_w;
  end

  assign pc_out   = pc_q;
  assign pc_plus4 = seq_w;

  AST_RESET_LOAD: assert property (@(posedge clk) rst |=> pc_q == RESET_ADDR); // R1
  AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (rst) pc_q[WORD_SHIFT-1:0] == '0); // R8
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst) (!jump_ctl && !branch_ctl) |=> pc_q == $past(pc_q) + addr_t'(STEP)); // R2
  AST_BR_TAKEN: assert property (@(posedge clk) disable iff (rst) (br_take_w && !jump_ctl) |=> pc_q == $past(br_tgt_w)); // R4
  AST_BR_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst) (branch_ctl && !zero_flag && !jump_ctl) |=> pc_q == $past(pc_plus4)); // R5
  AST_ZERO_IGNORED: assert property (@(posedge clk) disable iff (rst) (zero_flag && !branch_ctl && !jump_ctl) |=> pc_q == $past(pc_plus4)); // R6
  AST_JUMP_WINS: assert property (@(posedge clk) disable iff (rst) jump_ctl |=> (pc_q == $past(jmp_tgt_w)) && (src_w != SRC_JUMP || $past(src_w) == SRC_JUMP)); // R7
  AST_JUMP_REGION: assert property (@(posedge clk) disable iff (rst) jump_ctl |=> pc_q[XLEN-1 -: REGION_W] == $past(pc_plus4[XLEN-1 -: REGION_W])); // R9

endmodule

// File: tb/npc_gen_unit_tb_top.sv
module npc_gen_unit_tb_top;

  typedef struct packed {
    logic [31:0] instr;
    logic        zero;
    logic        br;
    logic        jmp;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{32'h0000_0000, 1'b0, 1'b0, 1'b0},  // R2 plain step
    '{32'h1000_0010, 1'b0, 1'b1, 1'b0},  // R5 branch, zero low
    '{32'h0000_0040, 1'b1, 1'b0, 1'b0},  // R6 zero alone
    '{32'h1000_0004, 1'b1, 1'b1, 1'b0},  // R4 forward branch
    '{32'h1000_FFFE, 1'b1, 1'b1, 1'b0},  // R4 backward branch
    '{32'h0800_0100, 1'b0, 1'b0, 1'b1},  // R7 jump
    '{32'h0800_0200, 1'b1, 1'b1, 1'b1},  // R7 jump beats taken branch
    '{32'h1000_7FFF, 1'b1, 1'b1, 1'b0},  // R4 largest forward offset
    '{32'h1000_8000, 1'b1, 1'b1, 1'b0},  // R4 largest backward offset
    '{32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0},  // R2 busy instruction, no controls
    '{32'h1000_FFFF, 1'b1, 1'b1, 1'b0},  // R4 branch to itself
    '{32'h0BFF_FFFF, 1'b0, 1'b0, 1'b1},  // R7 jump to top of region 0
    '{32'h0800_0000, 1'b0, 1'b1, 1'b1},  // R9 region taken from PC+4
    '{32'h0000_0000, 1'b1, 1'b1, 1'b0}   // R4 zero offset
  };

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] instr_word;
  logic        zero_flag;
  logic        branch_ctl;
  logic        jump_ctl;
  logic [31:0] pc_out;
  logic [31:0] pc_plus4;

  int   n_vec  = 0;
  int   n_miss = 0;
  bit   done   = 1'b0;
  logic [31:0] model_pc;

  always #4 clk = ~clk;

  npc_gen_unit dut_i (
    .clk        (clk),
    .rst        (rst),
    .instr_word (instr_word),
    .zero_flag  (zero_flag),
    .branch_ctl (branch_ctl),
    .jump_ctl   (jump_ctl),
    .pc_out     (pc_out),
    .pc_plus4   (pc_plus4)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_miss++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  // Next address worked out by hand from the requirements.
  function automatic logic [31:0] predict(input logic [31:0] pc, input logic [31:0] ins,
                                          input logic z, input logic b, input logic j);
    logic [31:0] nxt;
    int          disp;
    nxt  = pc + 32'd4;
    disp = int'($signed(ins[15:0])) * 4;
    if (j)          return (nxt & 32'hF000_0000) | ({6'd0, ins[25:0]} * 32'd4);
    else if (b && z) return nxt + 32'(disp);
    else            return nxt;
  endfunction

  task automatic look(input string req);
    check(req, pc_out, model_pc);
    check("R3", pc_plus4, model_pc + 32'd4);
    check("R8", {30'd0, pc_out[1:0]}, 32'd0);
  endtask

  // Called at a falling edge; applies one cycle and checks at the next falling edge.
  task automatic apply(input string req, input logic [31:0] ins,
                       input logic z, input logic b, input logic j);
    instr_word = ins;
    zero_flag  = z;
    branch_ctl = b;
    jump_ctl   = j;
    model_pc   = predict(model_pc, ins, z, b, j);
    @(negedge clk);
    look(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_miss++;
      $display("FAIL watchdog: got hang expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
      $finish;
    end
  end

  initial begin
    rst        = 1'b1;
    instr_word = '0;
    zero_flag  = 1'b0;
    branch_ctl = 1'b0;
    jump_ctl   = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    model_pc = 32'd0;
    look("R1");
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++)
      apply("R2/R4/R5/R6/R7 vector", VECS[i].instr, VECS[i].zero, VECS[i].br, VECS[i].jmp);

    // R10: reset during a jump and a taken branch
    rst        = 1'b1;
    instr_word = 32'h0812_3456;
    jump_ctl   = 1'b1;
    branch_ctl = 1'b1;
    zero_flag  = 1'b1;
    @(negedge clk);
    model_pc = 32'd0;
    look("R10");
    @(negedge clk);
    look("R1");
    rst      = 1'b0;
    jump_ctl = 1'b0;

    // R9: walk every jump region up to the top of memory, then wrap
    for (int r = 0; r < 16; r++)
      apply("R9 region walk", 32'h0BFF_FFFF, 1'b0, 1'b0, 1'b1);
    check("R9", model_pc, 32'hFFFF_FFFC);
    apply("R9 wrap", 32'h0000_0000, 1'b0, 1'b0, 1'b0);
    check("R9", pc_out, 32'h0000_0000);

    // R2: several plain steps in a row
    for (int k = 0; k < 4; k++)
      apply("R2", 32'h0000_0000, 1'b0, 1'b0, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  end

endmodule